// File: doc/BRIEF.md
# Redundant-Stage Result Voter with Dataset Retry

This block sits behind two or three identical processing stages that have each worked through the same dataset. Each cycle it may take one word from every stage, together with a per-lane flag that marks the word as unrecoverable by the memory's error-correcting code. Flagged lanes take no part in the vote. The surviving copies are compared, and the agreed value goes out as a registered result stream. Each result carries its index within the dataset and the buffer half it must be written to.

A word fails when no agreeing pair can be found among the surviving copies, or when no copy survives at all. When the last word of a dataset has been accepted, the block states the outcome. A clean dataset flips the buffer half used for results, so the next dataset writes to the other half. A dataset with any failed word leaves the buffer half as it is, so the source copy in the other half stays intact, and it raises a retry request. Consecutive retries are counted against a limit. Once that limit is used up, the next failure sets a sticky fatal flag, and the block then stops accepting words. A single surviving copy is passed through and marked degraded. A mode input chooses between dual and triple redundancy.

Top module: `stage_vote_unit`

## Requirements
- R1: After reset, outValid, setDone, setRetry and fatalErr are 0 and bankSel is 0.
- R2: In triple mode, with all three lanes valid and at least two equal, the output is the agreed value, with outErr=0 and outDegraded=0. The result appears on the clock edge that accepts the word.
- R3: A lane whose bad flag is 1 (laneBad bit i belongs to lane i) is left out of the vote. When the two remaining lanes agree, the output is their value with no error, whatever the excluded lane holds.
- R4: When exactly one lane survives, its word is output with outDegraded=1 and outErr=0.
- R5: When the surviving lanes hold no equal pair, outErr=1 and outData is the lowest-numbered surviving lane. When no lane survives, outErr=1 and outData=0.
- R6: With cfgTriple=0, lane 2 is ignored entirely. If the two surviving lanes differ, the word fails.
- R7: outIndex is 0 for the first word of a dataset and rises by one for each accepted word. It returns to 0 after the word marked inLast.
- R8: setDone pulses together with the result of the inLast word. outBank equals bankSel at the time the word is accepted. bankSel toggles, on that same edge, only when no word of the dataset failed.
- R9: When a dataset has a failed word and retries remain, setRetry pulses together with setDone and bankSel keeps its value.
- R10: Consecutive failed datasets are counted. After RETRY_MAX retries, the next failure sets fatalErr instead of setRetry. A clean dataset clears the count.
- R11: fatalErr stays set until reset. While it is set, words are not accepted and outValid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgTriple | input | 1 | 1: three stages vote, 0: two stages (lane 2 ignored) |
| inValid | input | 1 | A word set is present on the lanes |
| inLast | input | 1 | This word set closes the dataset |
| laneData0 | input | DATA_W | Word from stage 0 |
| laneData1 | input | DATA_W | Word from stage 1 |
| laneData2 | input | DATA_W | Word from stage 2 |
| laneBad | input | 3 | Per-lane uncorrectable-ECC flag, bit i for lane i |
| outValid | output | 1 | Voted result present |
| outData | output | DATA_W | Voted word |
| outIndex | output | IDX_W | Word position inside the dataset |
| outBank | output | 1 | Buffer half to write this result to |
| outErr | output | 1 | No majority for this word |
| outDegraded | output | 1 | Only one lane took part in the vote |
| setDone | output | 1 | Dataset closed (pulse) |
| setRetry | output | 1 | Dataset must be processed again (pulse) |
| fatalErr | output | 1 | Retry limit exhausted, sticky |
| bankSel | output | 1 | Buffer half currently receiving results |

## Verification
Closing a dataset and resolving its last word fall on the same edge. When the last word itself has no majority, that word's error decides the retry, the buffer flip and possibly the fatal flag, all at once. The bench closes datasets whose only failed word is the final one, and datasets whose failure is in an earlier word and followed by a clean last word. It then judges outErr, setDone, setRetry and bankSel together on that single edge. A second collision arises when the failure that uses up the retry limit also closes the dataset. That case is driven until fatalErr rises in place of setRetry.

// File: rtl/stage_vote_pkg.sv
package stage_vote_pkg;

  localparam int LANES = 3;

  // Strobes from control to datapath for one accepted word set
  typedef struct packed {
    logic capture;   // take the current word set
    logic lastWord;  // it closes the dataset
    logic bank;      // buffer half assigned to it
  } vote_strobe_t;

endpackage

// File: rtl/vote_core.sv
module vote_core #(
  parameter int DATA_W = 16
) (
  input  logic [stage_vote_pkg::LANES-1:0][DATA_W-1:0] laneWords,
  input  logic [stage_vote_pkg::LANES-1:0]             laneUse,
  output logic [DATA_W-1:0]                            voteData,
  output logic                                         voteErr,
  output logic                                         voteDeg
);
  localparam int PAIRS = 3;

  logic [PAIRS-1:0] pairHit;
  logic [1:0]       useCnt;

  // pair p compares lanes (0,1), (0,2), (1,2)
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int LA = (p == 2) ? 1 : 0;
    localparam int LB = (p == 0) ? 1 : 2;
    assign pairHit[p] = laneUse[LA] & laneUse[LB] &
                        (laneWords[LA] == laneWords[LB]);
  end

  assign useCnt = 2'(laneUse[0]) + 2'(laneUse[1]) + 2'(laneUse[2]);

  logic [DATA_W-1:0] lowestUsed;
  always_comb begin
    lowestUsed = '0;
    if (laneUse[0])      lowestUsed = laneWords[0];
    else if (laneUse[1]) lowestUsed = laneWords[1];
    else if (laneUse[2]) lowestUsed = laneWords[2];
  end

  always_comb begin
    voteData = '0;
    voteErr  = 1'b0;
    voteDeg  = 1'b0;
    if (useCnt == 2'd0) begin
      voteErr = 1'b1;
    end else if (useCnt == 2'd1) begin
      voteDeg  = 1'b1;
      voteData = lowestUsed;
    end else if (pairHit[0] || pairHit[1]) begin
      voteData = laneWords[0];
    end else if (pairHit[2]) begin
      voteData = laneWords[1];
    end else begin
      voteErr  = 1'b1;
      voteData = lowestUsed;
    end
  end

  always_comb begin
    if (useCnt == 2'd1) assert (!voteErr);  // AST_SINGLE_NOT_FAILED R4
  end

endmodule

// File: rtl/vote_datapath.sv
module vote_datapath
  import stage_vote_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  vote_strobe_t           strobe,
  input  logic [DATA_W-1:0]      laneData0,
  input  logic [DATA_W-1:0]      laneData1,
  input  logic [DATA_W-1:0]      laneData2,
  input  logic [LANES-1:0]       laneUse,
  output logic                   wordErr,
  output logic                   outValid,
  output logic [DATA_W-1:0]      outData,
  output logic [IDX_W-1:0]       outIndex,
  output logic                   outBank,
  output logic                   outErr,
  output logic                   outDegraded
);
  logic [LANES-1:0][DATA_W-1:0] laneWords;
  logic [DATA_W-1:0]            voteData;
  logic                         voteDeg;
  logic [IDX_W-1:0]             idxCnt;

  assign laneWords = {laneData2, laneData1, laneData0};

  vote_core #(.DATA_W(DATA_W)) u_core (
    .laneWords(laneWords),
    .laneUse  (laneUse),
    .voteData (voteData),
    .voteErr  (wordErr),
    .voteDeg  (voteDeg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idxCnt      <= '0;
      outValid    <= 1'b0;
      outData     <= '0;
      outIndex    <= '0;
      outBank     <= 1'b0;
      outErr      <= 1'b0;
      outDegraded <= 1'b0;
    end else begin
      outValid    <= strobe.capture;
      outErr      <= strobe.capture & wordErr;
      outDegraded <= strobe.capture & voteDeg;
      if (strobe.capture) begin
        outData  <= voteData;
        outIndex <= idxCnt;
        outBank  <= strobe.bank;
        idxCnt   <= strobe.lastWord ? '0 : idxCnt + 1'b1;
      end
    end
  end

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (!outErr && !outDegraded));  // R5
  AST_DEGRADED_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    outDegraded |-> !outErr);  // R4

endmodule

// File: rtl/vote_control.sv
module vote_control
  import stage_vote_pkg::*;
#(
  parameter int RETRY_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgTriple,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [LANES-1:0] laneBad,
  input  logic             wordErr,
  output vote_strobe_t     strobe,
  output logic [LANES-1:0] laneUse,
  output logic             setDone,
  output logic             setRetry,
  output logic             fatalErr,
  output logic             bankSel
);
  localparam int RETRY_W = $clog2(RETRY_MAX + 1);

  logic [RETRY_W-1:0] retryCnt;
  logic               setErrAcc;
  logic               setFailed;
  logic               closing;
  logic               retryLeft;

  assign laneUse   = ~laneBad & {cfgTriple, 1'b1, 1'b1};
  assign strobe    = '{capture: inValid & ~fatalErr, lastWord: inLast, bank: bankSel};
  assign closing   = strobe.capture & inLast;
  assign setFailed = setErrAcc | wordErr;
  assign retryLeft = (retryCnt < RETRY_W'(RETRY_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retryCnt  <= '0;
      setErrAcc <= 1'b0;
      setDone   <= 1'b0;
      setRetry  <= 1'b0;
      fatalErr  <= 1'b0;
      bankSel   <= 1'b0;
    end else begin
      setDone  <= closing;
      setRetry <= closing & setFailed & retryLeft;
      if (strobe.capture) setErrAcc <= inLast ? 1'b0 : setFailed;
      if (closing) begin
        if (!setFailed) begin
          bankSel  <= ~bankSel;
          retryCnt <= '0;
        end else if (retryLeft) begin
          retryCnt <= retryCnt + 1'b1;
        end else begin
          fatalErr <= 1'b1;
        end
      end
    end
  end

  AST_RETRY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    setRetry |-> setDone);  // R9
  AST_BANK_HOLD_ON_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    setRetry |-> $stable(bankSel));  // R9
  AST_BANK_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !setDone |-> $stable(bankSel));  // R8
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fatalErr |=> fatalErr);  // R11
  AST_FATAL_NOT_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatalErr) |-> !setRetry);  // R10

endmodule

// File: rtl/stage_vote_unit.sv
module stage_vote_unit
  import stage_vote_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 8,
  parameter int RETRY_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgTriple,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [DATA_W-1:0] laneData0,
  input  logic [DATA_W-1:0] laneData1,
  input  logic [DATA_W-1:0] laneData2,
  input  logic [2:0]        laneBad,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [IDX_W-1:0]  outIndex,
  output logic              outBank,
  output logic              outErr,
  output logic              outDegraded,
  output logic              setDone,
  output logic              setRetry,
  output logic              fatalErr,
  output logic              bankSel
);
  vote_strobe_t     strobe;
  logic [LANES-1:0] laneUse;
  logic             wordErr;

  vote_control #(.RETRY_MAX(RETRY_MAX)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgTriple(cfgTriple),
    .inValid  (inValid),
    .inLast   (inLast),
    .laneBad  (laneBad),
    .wordErr  (wordErr),
    .strobe   (strobe),
    .laneUse  (laneUse),
    .setDone  (setDone),
    .setRetry (setRetry),
    .fatalErr (fatalErr),
    .bankSel  (bankSel)
  );

  vote_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .laneData0  (laneData0),
    .laneData1  (laneData1),
    .laneData2  (laneData2),
    .laneUse    (laneUse),
    .wordErr    (wordErr),
    .outValid   (outValid),
    .outData    (outData),
    .outIndex   (outIndex),
    .outBank    (outBank),
    .outErr     (outErr),
    .outDegraded(outDegraded)
  );

  AST_NO_OUTPUT_WHEN_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    fatalErr |=> !outValid);  // R11
  AST_DONE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    setDone |-> outValid);  // R8

endmodule

// File: tb/stage_vote_unit_tb.sv
`timescale 1ns/1ps
module stage_vote_unit_tb;
  localparam int DATA_W    = 16;
  localparam int IDX_W     = 8;
  localparam int RETRY_MAX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgTriple = 1'b1;
  logic inValid = 1'b0;
  logic inLast = 1'b0;
  logic [DATA_W-1:0] laneData0 = '0, laneData1 = '0, laneData2 = '0;
  logic [2:0] laneBad = '0;
  logic outValid, outBank, outErr, outDegraded, setDone, setRetry, fatalErr, bankSel;
  logic [DATA_W-1:0] outData;
  logic [IDX_W-1:0] outIndex;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int expIdx = 0;
  int expBank = 0;
  int expRetry = 0;
  bit expFailAcc = 0;

  always #2.5 clk = ~clk;

  stage_vote_unit #(.DATA_W(DATA_W), .IDX_W(IDX_W), .RETRY_MAX(RETRY_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgTriple(cfgTriple), .inValid(inValid), .inLast(inLast),
    .laneData0(laneData0), .laneData1(laneData1), .laneData2(laneData2), .laneBad(laneBad),
    .outValid(outValid), .outData(outData), .outIndex(outIndex), .outBank(outBank),
    .outErr(outErr), .outDegraded(outDegraded), .setDone(setDone), .setRetry(setRetry),
    .fatalErr(fatalErr), .bankSel(bankSel)
  );

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Expected vote per requirements R2..R6: {err, deg, data}
  function automatic logic [DATA_W+1:0] model(int d0, int d1, int d2, logic [2:0] bad, bit triple);
    int v[$];
    logic [DATA_W-1:0] data;
    if (!bad[0]) v.push_back(d0);
    if (!bad[1]) v.push_back(d1);
    if (!bad[2] && triple) v.push_back(d2);
    if (v.size() == 0) return {1'b1, 1'b0, DATA_W'(0)};
    if (v.size() == 1) return {1'b0, 1'b1, DATA_W'(v[0])};
    for (int i = 0; i < v.size(); i++)
      for (int j = i + 1; j < v.size(); j++)
        if (v[i] == v[j]) begin
          data = DATA_W'(v[i]);
          return {1'b0, 1'b0, data};
        end
    return {1'b1, 1'b0, DATA_W'(v[0])};
  endfunction

  task automatic sendWord(string req, int d0, int d1, int d2, logic [2:0] bad, bit last);
    logic [DATA_W+1:0] m;
    m = model(d0, d1, d2, bad, cfgTriple);
    @(negedge clk);
    laneData0 = DATA_W'(d0); laneData1 = DATA_W'(d1); laneData2 = DATA_W'(d2);
    laneBad = bad; inLast = last; inValid = 1'b1;
    @(posedge clk); #1;
    check(req, "outValid", int'(outValid), 1);
    check(req, "outData", int'(outData), int'(m[DATA_W-1:0]));
    check(req, "outErr", int'(outErr), int'(m[DATA_W+1]));
    check(req, "outDegraded", int'(outDegraded), int'(m[DATA_W]));
    check("R7", "outIndex", int'(outIndex), expIdx);
    check("R8", "outBank", int'(outBank), expBank);
    check("R8", "setDone", int'(setDone), int'(last));
    expFailAcc = expFailAcc | m[DATA_W+1];
    if (last) begin
      if (expFailAcc) begin
        if (expRetry < RETRY_MAX) begin
          check("R9", "setRetry", int'(setRetry), 1);
          check("R9", "bankSel held", int'(bankSel), expBank);
          check("R10", "fatalErr", int'(fatalErr), 0);
          expRetry++;
        end else begin
          check("R10", "fatalErr", int'(fatalErr), 1);
          check("R10", "setRetry", int'(setRetry), 0);
        end
      end else begin
        expBank = expBank ^ 1;
        expRetry = 0;
        check("R8", "setRetry", int'(setRetry), 0);
        check("R8", "bankSel toggled", int'(bankSel), expBank);
      end
      expIdx = 0;
      expFailAcc = 0;
    end else begin
      expIdx++;
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; laneBad = '0;
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    check("R1", "outValid", int'(outValid), 0);
    check("R1", "setDone", int'(setDone), 0);
    check("R1", "setRetry", int'(setRetry), 0);
    check("R1", "fatalErr", int'(fatalErr), 0);
    check("R1", "bankSel", int'(bankSel), 0);
  endtask

  task automatic t_tmr();  // R2
    cfgTriple = 1'b1;
    sendWord("R2", 5, 5, 5, 3'b000, 0);
    sendWord("R2", 9, 3, 9, 3'b000, 0);
    sendWord("R2", 1, 7, 7, 3'b000, 1);
  endtask

  task automatic t_ecc();  // R3
    sendWord("R3", 4, 8, 8, 3'b001, 0);
    sendWord("R3", 6, 3, 6, 3'b010, 0);
    sendWord("R3", 2, 2, 9, 3'b100, 1);
  endtask

  task automatic t_single();  // R4
    sendWord("R4", 11, 12, 13, 3'b101, 0);
    sendWord("R4", 21, 22, 23, 3'b011, 1);
  endtask

  task automatic t_nomajority();  // R5, R9: earlier word fails, clean last word
    sendWord("R5", 1, 2, 3, 3'b000, 0);
    sendWord("R9", 7, 7, 7, 3'b000, 1);
    sendWord("R10", 7, 7, 7, 3'b000, 1);  // clean dataset clears count
    sendWord("R5", 1, 2, 3, 3'b111, 1);   // only word fails on the closing edge
    sendWord("R5", 4, 6, 4, 3'b100, 1);   // two left, differ
    sendWord("R10", 3, 3, 3, 3'b000, 1);
  endtask

  task automatic t_dmr();  // R6
    cfgTriple = 1'b0;
    sendWord("R6", 5, 5, 9, 3'b000, 0);
    sendWord("R6", 3, 3, 3, 3'b010, 0);
    sendWord("R6", 4, 6, 4, 3'b000, 1);
    sendWord("R6", 8, 8, 1, 3'b000, 1);
    sendWord("R6", 1, 1, 1, 3'b011, 1);
    sendWord("R6", 2, 2, 0, 3'b000, 1);
    cfgTriple = 1'b1;
  endtask

  task automatic t_retry_limit();  // R10, R11
    sendWord("R10", 1, 2, 3, 3'b000, 1);
    sendWord("R10", 5, 5, 5, 3'b000, 1);
    sendWord("R10", 1, 2, 3, 3'b000, 1);
    sendWord("R10", 1, 2, 3, 3'b000, 1);
    sendWord("R10", 1, 2, 3, 3'b000, 1);  // limit used up -> fatal
    @(negedge clk);
    laneData0 = 16'd9; laneData1 = 16'd9; laneData2 = 16'd9; inValid = 1'b1; inLast = 1'b1;
    @(posedge clk); #1;
    check("R11", "outValid while fatal", int'(outValid), 0);
    check("R11", "setDone while fatal", int'(setDone), 0);
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R11", "fatalErr sticky", int'(fatalErr), 1);
    check("R11", "bankSel unchanged", int'(bankSel), expBank);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_tmr();
    t_ecc();
    t_single();
    t_nomajority();
    t_dmr();
    t_retry_limit();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule